// File: doc/BRIEF.md
# Integer Register File with Deferral Tags

This block is the integer operand store of an execute cluster that supports speculative loads. Each of its 128 entries holds a 64-bit value together with a one-bit deferral tag. A set tag marks the value as invalid because the speculation that produced it was deferred. Two read ports and one write port each carry a value and its tag. Entry 0 is a hardwired constant: it reads as zero with a clear tag, and it cannot be written.

An execute-side tag checker sits beside the file. It watches the tags that the two read ports deliver. For an arithmetic operation it forms the result tag as the OR of the tags of the operands in use, so that deferral passes on to the destination. For any other use of a tagged operand, such as a store, it raises a fault. An attempt to write entry 0 also raises a fault. Faults appear as a registered one-cycle strobe with a 2-bit cause code. Each read port also reports whether its index falls in the static group, entries 0 to 31, or in the upper group that later stages may renumber.

Top module: `intreg_tagfile`

## Requirements
- R1: A write with `wr_en` high to an index from 1 to 127 stores the value. The value reads back on any port from the next cycle onward, and writes to other entries leave it unchanged.
- R2: Each entry stores its tag bit independently of its 64 value bits, and a read returns the stored tag alongside the value.
- R3: A read of index 0 returns value 0 and tag 0 on that port. This holds even while a write to index 0 is presented in the same cycle.
- R4: A write to index 0 changes no entry. One cycle later it produces `fault_valid` = 1 with `fault_cause` = 2'b01.
- R5: `res_tag` is 1 only when `op_valid` and `op_arith` are high and port A's tag is set, or `op_use_b` is high and port B's tag is set. When `op_use_b` is low, port B's tag has no effect.
- R6: A non-arithmetic operation (`op_valid` = 1, `op_arith` = 0) whose in-use operand carries a tag produces `fault_valid` = 1 with `fault_cause` = 2'b10 one cycle later. Arithmetic operations never fault on tags.
- R7: When a write to a nonzero index occurs in the same cycle as a read of that index, the read port returns the new value and tag in that cycle.
- R8: Asserting `rst_n` low clears every value and tag to 0 and clears the fault outputs.
- R9: `fault_valid` is high for exactly one cycle per offending input cycle, and `fault_cause` is 2'b00 whenever `fault_valid` is low. If both fault conditions occur in one cycle, cause 2'b01 wins.
- R10: `rda_static` and `rdb_static` are 1 for indices 0 to 31 and 0 for indices 32 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 7 | Write index |
| wr_val | input | 64 | Write value |
| wr_tag | input | 1 | Write deferral tag |
| rda_idx | input | 7 | Port A read index |
| rda_val | output | 64 | Port A value |
| rda_tag | output | 1 | Port A deferral tag |
| rda_static | output | 1 | Port A index lies in the static group |
| rdb_idx | input | 7 | Port B read index |
| rdb_val | output | 64 | Port B value |
| rdb_tag | output | 1 | Port B deferral tag |
| rdb_static | output | 1 | Port B index lies in the static group |
| op_valid | input | 1 | An operation consumes the read operands this cycle |
| op_arith | input | 1 | 1 = arithmetic operation, 0 = other use |
| op_use_b | input | 1 | Operand B is in use |
| res_tag | output | 1 | Result deferral tag |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_cause | output | 2 | 00 none, 01 write to entry 0, 10 tagged operand in a non-arithmetic use |

## Verification
The bench writes index 0 while reading it on the same port. A design that forwarded the write or stored it would show a nonzero value and would also lose the fault. It sets up a tagged operand on port B with `op_use_b` low, which catches a checker that ORs in every tag regardless of use. Two tests drive the edges of the static group and the same-cycle write/read collision; an off-by-one group compare or a missing bypass shows up as a wrong indicator or a stale value. A combined zero-write and tagged store in one cycle exposes an inverted cause priority, and a full reset after writes shows any entry that keeps its old value.

// File: rtl/intreg_pkg.sv
package intreg_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ZERO_WR = 2'd1,
    FLT_TAG_USE = 2'd2
  } flt_cause_e;
endpackage

// File: rtl/intreg_store.sv
module intreg_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_val,
  input  logic                           wr_tag,
  output logic [DEPTH-1:0][DATA_W-1:0]   ent_val,
  output logic [DEPTH-1:0]               ent_tag
);
  // entry 0 holds no storage: it is a constant zero with a clear tag
  assign ent_val[0] = '0;
  assign ent_tag[0] = 1'b0;

  for (genvar g = 1; g < DEPTH; g++) begin : g_ent
    logic              we;
    logic [DATA_W-1:0] val_q, val_d;
    logic              tag_q, tag_d;

    assign we = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      val_d = val_q;
      tag_d = tag_q;
      if (we) begin
        val_d = wr_val;
        tag_d = wr_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        tag_q <= 1'b0;
      end else begin
        val_q <= val_d;
        tag_q <= tag_d;
      end
    end

    assign ent_val[g] = val_q;
    assign ent_tag[g] = tag_q;
  end
endmodule

// File: rtl/intreg_rdport.sv
module intreg_rdport #(
  parameter int DEPTH      = 128,
  parameter int DATA_W     = 64,
  parameter int STATIC_CNT = 32,
  parameter int IDX_W      = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             rd_idx,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_val,
  input  logic [DEPTH-1:0]             ent_tag,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_val,
  input  logic                         wr_tag,
  output logic [DATA_W-1:0]            rd_val,
  output logic                         rd_tag,
  output logic                         rd_static
);
  logic hit_zero, hit_wr;

  assign hit_zero = (rd_idx == '0);
  assign hit_wr   = wr_en && (wr_idx == rd_idx);

  always_comb begin
    if (hit_zero) begin
      rd_val = '0;
      rd_tag = 1'b0;
    end else if (hit_wr) begin
      rd_val = wr_val;
      rd_tag = wr_tag;
    end else begin
      rd_val = ent_val[rd_idx];
      rd_tag = ent_tag[rd_idx];
    end
  end

  assign rd_static = (32'(rd_idx) < STATIC_CNT);
endmodule

// File: rtl/intreg_tagcheck.sv
module intreg_tagcheck
  import intreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_a,
  input  logic             tag_b,
  input  logic             op_valid,
  input  logic             op_arith,
  input  logic             op_use_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             res_tag,
  output logic             fault_valid,
  output logic [1:0]       fault_cause
);
  logic       any_tag;
  logic       zero_wr;
  logic       bad_use;
  logic       flt_v_d, flt_v_q;
  flt_cause_e flt_c_d, flt_c_q;

  assign any_tag = tag_a || (op_use_b && tag_b);
  assign res_tag = op_valid && op_arith && any_tag;
  assign zero_wr = wr_en && (wr_idx == '0);
  assign bad_use = op_valid && !op_arith && any_tag;

  always_comb begin
    flt_v_d = 1'b0;
    flt_c_d = FLT_NONE;
    if (zero_wr) begin
      flt_v_d = 1'b1;
      flt_c_d = FLT_ZERO_WR;
    end else if (bad_use) begin
      flt_v_d = 1'b1;
      flt_c_d = FLT_TAG_USE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_v_q <= 1'b0;
      flt_c_q <= FLT_NONE;
    end else begin
      flt_v_q <= flt_v_d;
      flt_c_q <= flt_c_d;
    end
  end

  assign fault_valid = flt_v_q;
  assign fault_cause = flt_c_q;
endmodule

// File: rtl/intreg_tagfile.sv
module intreg_tagfile #(
  parameter int DEPTH      = 128,
  parameter int DATA_W     = 64,
  parameter int STATIC_CNT = 32,
  parameter int IDX_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_val,
  input  logic              wr_tag,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic [DATA_W-1:0] rda_val,
  output logic              rda_tag,
  output logic              rda_static,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic [DATA_W-1:0] rdb_val,
  output logic              rdb_tag,
  output logic              rdb_static,
  input  logic              op_valid,
  input  logic              op_arith,
  input  logic              op_use_b,
  output logic              res_tag,
  output logic              fault_valid,
  output logic [1:0]        fault_cause
);
  localparam int NRD = 2;

  logic [DEPTH-1:0][DATA_W-1:0] ent_val;
  logic [DEPTH-1:0]             ent_tag;
  logic [NRD-1:0][IDX_W-1:0]    p_idx;
  logic [NRD-1:0][DATA_W-1:0]   p_val;
  logic [NRD-1:0]               p_tag;
  logic [NRD-1:0]               p_static;

  intreg_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag),
    .ent_val(ent_val), .ent_tag(ent_tag)
  );

  assign p_idx[0] = rda_idx;
  assign p_idx[1] = rdb_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    intreg_rdport #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STATIC_CNT(STATIC_CNT),
                    .IDX_W(IDX_W)) u_rd (
      .rd_idx(p_idx[p]), .ent_val(ent_val), .ent_tag(ent_tag),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag),
      .rd_val(p_val[p]), .rd_tag(p_tag[p]), .rd_static(p_static[p])
    );
  end

  assign rda_val    = p_val[0];
  assign rda_tag    = p_tag[0];
  assign rda_static = p_static[0];
  assign rdb_val    = p_val[1];
  assign rdb_tag    = p_tag[1];
  assign rdb_static = p_static[1];

  intreg_tagcheck #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tag_a(p_tag[0]), .tag_b(p_tag[1]),
    .op_valid(op_valid), .op_arith(op_arith), .op_use_b(op_use_b),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .res_tag(res_tag), .fault_valid(fault_valid), .fault_cause(fault_cause)
  );
endmodule

// File: rtl/intreg_tagfile_chk.sv
module intreg_tagfile_chk #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_val,
  input logic              wr_tag,
  input logic [IDX_W-1:0]  rda_idx,
  input logic [DATA_W-1:0] rda_val,
  input logic              rda_tag,
  input logic              rda_static,
  input logic [IDX_W-1:0]  rdb_idx,
  input logic [DATA_W-1:0] rdb_val,
  input logic              rdb_tag,
  input logic              rdb_static,
  input logic              op_valid,
  input logic              op_arith,
  input logic              op_use_b,
  input logic              res_tag,
  input logic              fault_valid,
  input logic [1:0]        fault_cause
);
  AST_ZERO_READS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_idx == '0) |-> (rda_val == '0 && !rda_tag)); // R3

  AST_ZERO_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0) |=> (fault_valid && fault_cause == 2'b01)); // R4

  AST_WRITE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=>
      ((rda_idx == $past(wr_idx) && !(wr_en && wr_idx == rda_idx)) ->
        (rda_val == $past(wr_val) && rda_tag == $past(wr_tag)))); // R1

  AST_BYPASS_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0 && wr_idx == rdb_idx) |->
      (rdb_val == wr_val && rdb_tag == wr_tag)); // R7

  AST_ARITH_TAG_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_arith && rda_tag) |-> res_tag); // R5

  AST_ARITH_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_arith && !(wr_en && wr_idx == '0)) |=> !fault_valid); // R6

  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> (fault_cause == 2'b00)); // R9

  AST_STATIC_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rda_idx == IDX_W'(32)) |-> !rda_static); // R10
endmodule

bind intreg_tagfile intreg_tagfile_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_tagfile_chk (.*);

// File: tb/intreg_tagfile_tb.sv
`timescale 1ns/1ps
module intreg_tagfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [63:0] wr_val;
  logic        wr_tag;
  logic [6:0]  rda_idx, rdb_idx;
  logic [63:0] rda_val, rdb_val;
  logic        rda_tag, rdb_tag, rda_static, rdb_static;
  logic        op_valid, op_arith, op_use_b;
  logic        res_tag, fault_valid;
  logic [1:0]  fault_cause;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  intreg_tagfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_tag(wr_tag),
    .rda_idx(rda_idx), .rda_val(rda_val), .rda_tag(rda_tag), .rda_static(rda_static),
    .rdb_idx(rdb_idx), .rdb_val(rdb_val), .rdb_tag(rdb_tag), .rdb_static(rdb_static),
    .op_valid(op_valid), .op_arith(op_arith), .op_use_b(op_use_b),
    .res_tag(res_tag), .fault_valid(fault_valid), .fault_cause(fault_cause)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = '0; wr_val = '0; wr_tag = 0;
    op_valid = 0; op_arith = 0; op_use_b = 0;
  endtask

  task automatic wr(input logic [6:0] i, input logic [63:0] v, input logic t);
    wr_en = 1; wr_idx = i; wr_val = v; wr_tag = t;
    step();
    idle();
  endtask

  task automatic t_reset_state();
    rda_idx = 7'd5; rdb_idx = 7'd127; #1;
    chk(rda_val == 0 && !rda_tag, "R8 entry 5 after reset", rda_val, 0);
    chk(rdb_val == 0 && !rdb_tag, "R8 entry 127 after reset", rdb_val, 0);
    chk(!fault_valid && fault_cause == 0, "R8 fault idle after reset", fault_cause, 0);
  endtask

  task automatic t_write_read();
    wr(7'd7, 64'h0123_4567_89AB_CDEF, 1'b0);
    wr(7'd127, 64'hFEED_FACE_CAFE_0001, 1'b1);
    rda_idx = 7'd7; rdb_idx = 7'd127; #1;
    chk(rda_val == 64'h0123_4567_89AB_CDEF, "R1 entry 7 value", rda_val, 64'h0123_4567_89AB_CDEF);
    chk(!rda_tag, "R2 entry 7 tag clear", rda_tag, 0);
    chk(rdb_val == 64'hFEED_FACE_CAFE_0001, "R1 entry 127 value", rdb_val, 64'hFEED_FACE_CAFE_0001);
    chk(rdb_tag, "R2 entry 127 tag set", rdb_tag, 1);
  endtask

  task automatic t_zero_write();
    rda_idx = 7'd0;
    wr_en = 1; wr_idx = 7'd0; wr_val = 64'hFFFF_FFFF_FFFF_FFFF; wr_tag = 1; #1;
    chk(rda_val == 0 && !rda_tag, "R3 index 0 during write", rda_val, 0);
    step();
    idle(); #1;
    chk(rda_val == 0 && !rda_tag, "R4 index 0 unchanged", rda_val, 0);
    chk(fault_valid && fault_cause == 2'b01, "R4 zero write fault", {62'd0, fault_cause}, 1);
    step();
    chk(!fault_valid && fault_cause == 0, "R9 fault one cycle", {63'd0, fault_valid}, 0);
  endtask

  task automatic t_bypass();
    rdb_idx = 7'd9;
    wr_en = 1; wr_idx = 7'd9; wr_val = 64'hA5A5_0000_5A5A_1111; wr_tag = 1; #1;
    chk(rdb_val == 64'hA5A5_0000_5A5A_1111 && rdb_tag, "R7 same-cycle bypass",
        rdb_val, 64'hA5A5_0000_5A5A_1111);
    step();
    idle();
  endtask

  task automatic t_arith();
    rda_idx = 7'd7; rdb_idx = 7'd127;
    op_valid = 1; op_arith = 1; op_use_b = 1; #1;
    chk(res_tag, "R5 tagged B propagates", res_tag, 1);
    op_use_b = 0; #1;
    chk(!res_tag, "R5 unused B ignored", res_tag, 0);
    rda_idx = 7'd127; rdb_idx = 7'd7; op_use_b = 1; #1;
    chk(res_tag, "R5 tagged A propagates", res_tag, 1);
    step();
    idle(); #1;
    chk(!fault_valid, "R6 arithmetic no fault", fault_valid, 0);
  endtask

  task automatic t_nonarith();
    rda_idx = 7'd7; rdb_idx = 7'd127;
    op_valid = 1; op_arith = 0; op_use_b = 0;
    step();
    chk(!fault_valid, "R6 untagged store no fault", fault_valid, 0);
    op_use_b = 1;
    step();
    idle(); #1;
    chk(fault_valid && fault_cause == 2'b10, "R6 tagged store fault", {62'd0, fault_cause}, 2);
    step();
    chk(!fault_valid && fault_cause == 0, "R9 tag fault clears", fault_cause, 0);
  endtask

  task automatic t_priority();
    rda_idx = 7'd127; op_valid = 1; op_arith = 0; op_use_b = 0;
    wr_en = 1; wr_idx = 7'd0; wr_val = 64'd3; wr_tag = 0;
    step();
    idle(); #1;
    chk(fault_valid && fault_cause == 2'b01, "R9 zero write wins", {62'd0, fault_cause}, 1);
    step();
  endtask

  task automatic t_group();
    rda_idx = 7'd31; rdb_idx = 7'd32; #1;
    chk(rda_static, "R10 index 31 static", rda_static, 1);
    chk(!rdb_static, "R10 index 32 upper", rdb_static, 0);
    rda_idx = 7'd127; rdb_idx = 7'd0; #1;
    chk(!rda_static && rdb_static, "R10 indices 127 and 0", {62'd0, rda_static, rdb_static}, 1);
  endtask

  task automatic t_reset_clear();
    rst_n = 0; #3;
    rst_n = 1;
    step();
    rda_idx = 7'd7; rdb_idx = 7'd127; #1;
    chk(rda_val == 0 && !rda_tag, "R8 entry 7 cleared", rda_val, 0);
    chk(rdb_val == 0 && !rdb_tag, "R8 entry 127 cleared", rdb_val, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rda_idx = '0; rdb_idx = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset_state();
    t_write_read();
    t_zero_write();
    t_bypass();
    t_arith();
    t_nonarith();
    t_priority();
    t_group();
    t_reset_clear();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule